// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the destination address at the head of each frame, whether the frame should be kept. A frame is framed by a start flag on its first byte and an end flag on its last byte. Any byte is qualified by a valid signal. The filter gathers the first six bytes. It compares them against two programmable unicast addresses and against the all-ones broadcast address. It also looks the address up in a 64-bit group hash table, whose 6-bit index is the XOR-fold of the 48 address bits.

The decision leaves the block as a one-cycle strobe with an accept bit. The strobe fires the cycle after the sixth byte. A separate one-cycle flag marks frames that end with fewer than the minimum number of bytes. Downstream logic must discard such frames whatever the address decision was. At each start of frame the configuration is copied into a shadow. Software may therefore rewrite it at any time without corrupting a frame already in flight.

Top module: `rx_addr_filter`

## Requirements
- R1: Unicast address 0 is formed from two words: byte k of the address (k = 0..3, byte 0 is the first on the stream) is bits 8k+7:8k of `cfgMa0Lo`, bytes 4 and 5 are bits 7:0 and 15:8 of `cfgMa0Hi`. When `cfgRxCtrl[0]` is 1, a frame whose six destination bytes equal this address is accepted.
- R2: Unicast address 1 is formed the same way from `cfgMa1Lo` and `cfgMa1Hi`. It is matched when `cfgRxCtrl[1]` is 1.
- R3: When `cfgRxCtrl[3]` is 1, a frame whose destination is all ones (FF on all six bytes) is accepted.
- R4: The group hash index is the XOR of eight 6-bit chunks. The chunks are cut from the address taken as a 48-bit value with byte 0 in bits 7:0 and byte 5 in bits 47:40, where chunk k is bits 6k+5:6k.
- R5: An index of 0..31 selects that bit of `cfgGrpLo`, and an index of 32..63 selects bit (index-32) of `cfgGrpHi`. The hash matches when the selected bit is 1.
- R6: The hash lookup takes part in the decision only when bit 0 of byte 0 (the group bit) is 1, or when `cfgRxCtrl[2]` is 1.
- R7: `decValid` is high for exactly one cycle, the cycle after the sixth byte of a frame is taken. `decAccept` is high only together with `decValid`, and it is high exactly when any enabled unicast match, the broadcast match or the hash match holds. A frame that ends before its sixth byte produces no strobe.
- R8: `runtFlag` is high for one cycle, the cycle after the byte carrying `frmEof`, when the frame held fewer than 12 bytes (the byte with `frmSof` counts as the first). Otherwise it stays low.
- R9: The unicast, group and control settings used for a frame are those present on the byte carrying `frmSof`. Changes made later in that frame only affect the next frame.
- R10: During and right after reset, `decValid`, `decAccept` and `runtFlag` are low.
- R11: Valid bytes that arrive outside a frame (before any `frmSof`, or after `frmEof`) are ignored. A `frmSof` arriving inside a frame restarts the byte count with that byte as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frmValid | input | 1 | Byte on `frmData` is valid this cycle |
| frmSof | input | 1 | Valid byte is the first byte of a frame |
| frmEof | input | 1 | Valid byte is the last byte of a frame |
| frmData | input | 8 | Received byte |
| cfgMa0Lo | input | 32 | Unicast address 0, bytes 0..3 |
| cfgMa0Hi | input | 16 | Unicast address 0, bytes 4..5 |
| cfgMa1Lo | input | 32 | Unicast address 1, bytes 0..3 |
| cfgMa1Hi | input | 16 | Unicast address 1, bytes 4..5 |
| cfgGrpLo | input | 32 | Group hash table, entries 0..31 |
| cfgGrpHi | input | 32 | Group hash table, entries 32..63 |
| cfgRxCtrl | input | 4 | Enables: 0 unicast 0, 1 unicast 1, 2 hash on individual addresses, 3 broadcast |
| decValid | output | 1 | Decision strobe |
| decAccept | output | 1 | Frame accepted (with `decValid`) |
| runtFlag | output | 1 | Frame shorter than the minimum length |

## Verification
The bench builds the filter with its defaults: a 12-byte runt threshold and a 6-bit hash index. With these values every runt length from 1 to 11 bytes is reachable with short frames, as are frames that end before the decision point, and both halves of the 64-entry group table. Random addresses and random table contents spread hits over many indices. Directed addresses pin indices 1, 4 and 33. Random frames with idle gaps, stray bytes, restarts and configuration writes in mid-frame exercise the snapshot and framing rules against the per-cycle model.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int POS_W      = $clog2(ADDR_BYTES);

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic             capCfg;   // take a configuration snapshot
    logic             takeByte; // current byte belongs to the address field
    logic [POS_W-1:0] bytePos;  // position of that byte within the address
    logic             lastAddr; // current byte completes the address
  } rxafStrobe_t;

  typedef struct packed {
    logic [31:0] ma0Lo;
    logic [15:0] ma0Hi;
    logic [31:0] ma1Lo;
    logic [15:0] ma1Hi;
    logic [31:0] grpLo;
    logic [31:0] grpHi;
    logic [3:0]  rxCtl;
  } rxafCfg_t;
endpackage

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
  parameter int ADDR_W  = 48,
  parameter int INDEX_W = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [INDEX_W-1:0] idx
);
  localparam int NUM_CHUNKS = ADDR_W / INDEX_W;

  logic [INDEX_W-1:0] partial [NUM_CHUNKS+1];

  assign partial[0] = '0;
  for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_fold
    assign partial[k+1] = partial[k] ^ addr[k*INDEX_W +: INDEX_W];
  end

  assign idx = partial[NUM_CHUNKS];
endmodule

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
  import rxaf_pkg::*;
#(
  parameter int MIN_FRAME = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmValid,
  input  logic        frmSof,
  input  logic        frmEof,
  output rxafStrobe_t strb,
  output logic        runtFlag
);
  localparam int CNT_W = $clog2(MIN_FRAME + 1);

  logic             inFrame;
  logic [CNT_W-1:0] byteCnt;
  logic             startNow;
  logic             active;
  logic [CNT_W-1:0] curIdx;
  logic [CNT_W-1:0] nextCnt;
  logic             frameEnd;
  logic             isRunt;

  always_comb begin
    startNow = frmValid && frmSof;
    active   = frmValid && (frmSof || inFrame);
    curIdx   = startNow ? '0 : byteCnt;
    nextCnt  = (curIdx == CNT_W'(MIN_FRAME)) ? curIdx : curIdx + 1'b1;
    frameEnd = active && frmEof;
    isRunt   = nextCnt < CNT_W'(MIN_FRAME);

    strb.capCfg   = startNow;
    strb.takeByte = active && (curIdx < CNT_W'(ADDR_BYTES));
    strb.bytePos  = curIdx[POS_W-1:0];
    strb.lastAddr = active && (curIdx == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      byteCnt  <= '0;
      runtFlag <= 1'b0;
    end else begin
      runtFlag <= frameEnd && isRunt;
      if (active) begin
        inFrame <= !frmEof;
        byteCnt <= nextCnt;
      end
    end
  end

  // R8: the counter saturates at the runt threshold
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CNT_W'(MIN_FRAME));

  // R11: an address byte is only taken inside a frame or on its first byte
  p_take_in_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeByte |-> (inFrame || frmSof));
endmodule

// File: rtl/rxaf_datapath.sv
module rxaf_datapath
  import rxaf_pkg::*;
#(
  parameter int INDEX_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  rxafStrobe_t strb,
  input  logic [7:0]  frmData,
  input  rxafCfg_t    cfgIn,
  output logic        decValid,
  output logic        decAccept
);
  localparam int TABLE_BITS = 1 << INDEX_W;

  rxafCfg_t           cfgQ;
  logic [7:0]         addrQ [ADDR_BYTES-1];
  logic [ADDR_W-1:0]  fullAddr;
  logic [ADDR_W-1:0]  uc0Addr;
  logic [ADDR_W-1:0]  uc1Addr;
  logic [INDEX_W-1:0] hashIdx;
  logic [TABLE_BITS-1:0] grpTable;
  logic               uc0Hit, uc1Hit, bcHit, grpHit, acceptNow;

  // Assemble the address: stored bytes plus the byte on the bus now
  for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_asm
    assign fullAddr[k*8 +: 8] = addrQ[k];
  end
  assign fullAddr[ADDR_W-1 -: 8] = frmData;

  assign uc0Addr  = {cfgQ.ma0Hi, cfgQ.ma0Lo};
  assign uc1Addr  = {cfgQ.ma1Hi, cfgQ.ma1Lo};
  assign grpTable = TABLE_BITS'({cfgQ.grpHi, cfgQ.grpLo});

  rxaf_hash #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_hash (
    .addr (fullAddr),
    .idx  (hashIdx)
  );

  always_comb begin
    uc0Hit    = cfgQ.rxCtl[0] && (fullAddr == uc0Addr);
    uc1Hit    = cfgQ.rxCtl[1] && (fullAddr == uc1Addr);
    bcHit     = cfgQ.rxCtl[3] && (&fullAddr);
    grpHit    = (fullAddr[0] || cfgQ.rxCtl[2]) && grpTable[hashIdx];
    acceptNow = uc0Hit || uc1Hit || bcHit || grpHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      for (int k = 0; k < ADDR_BYTES - 1; k++) addrQ[k] <= '0;
    end else begin
      if (strb.capCfg) cfgQ <= cfgIn;
      if (strb.takeByte) begin
        for (int k = 0; k < ADDR_BYTES - 1; k++)
          if (strb.bytePos == POS_W'(k)) addrQ[k] <= frmData;
      end
      decValid  <= strb.lastAddr;
      decAccept <= strb.lastAddr && acceptNow;
    end
  end

  // R1: an enabled unicast-0 match is accepted on the following strobe
  p_uc0_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastAddr && cfgQ.rxCtl[0] && fullAddr == uc0Addr) |=> decAccept);

  // R3: an enabled broadcast is accepted on the following strobe
  p_bcast_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastAddr && cfgQ.rxCtl[3] && (&fullAddr)) |=> decAccept);

  // R7: accept only appears with the strobe
  p_accept_with_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> decValid);

  // R9: the snapshot only moves at a start of frame
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capCfg |=> $stable(cfgQ));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int MIN_FRAME = 12,
  parameter int INDEX_W   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmValid,
  input  logic        frmSof,
  input  logic        frmEof,
  input  logic [7:0]  frmData,
  input  logic [31:0] cfgMa0Lo,
  input  logic [15:0] cfgMa0Hi,
  input  logic [31:0] cfgMa1Lo,
  input  logic [15:0] cfgMa1Hi,
  input  logic [31:0] cfgGrpLo,
  input  logic [31:0] cfgGrpHi,
  input  logic [3:0]  cfgRxCtrl,
  output logic        decValid,
  output logic        decAccept,
  output logic        runtFlag
);
  rxafStrobe_t strb;
  rxafCfg_t    cfgBus;

  assign cfgBus = '{ma0Lo: cfgMa0Lo, ma0Hi: cfgMa0Hi, ma1Lo: cfgMa1Lo,
                    ma1Hi: cfgMa1Hi, grpLo: cfgGrpLo, grpHi: cfgGrpHi,
                    rxCtl: cfgRxCtrl};

  rxaf_ctrl #(.MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .frmSof   (frmSof),
    .frmEof   (frmEof),
    .strb     (strb),
    .runtFlag (runtFlag)
  );

  rxaf_datapath #(.INDEX_W(INDEX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .frmData   (frmData),
    .cfgIn     (cfgBus),
    .decValid  (decValid),
    .decAccept (decAccept)
  );

  // R7: a strobe always follows a taken byte
  p_dec_after_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(frmValid));

  // R8: the runt flag always follows an end-of-frame byte
  p_runt_after_eof_r8: assert property (@(posedge clk) disable iff (!rstN)
    runtFlag |-> $past(frmValid && frmEof));
endmodule

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/100ps
module rx_addr_filter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        frmValid = 0, frmSof = 0, frmEof = 0;
  logic [7:0]  frmData = 0;
  logic [31:0] cfgMa0Lo = 0, cfgMa1Lo = 0, cfgGrpLo = 0, cfgGrpHi = 0;
  logic [15:0] cfgMa0Hi = 0, cfgMa1Hi = 0;
  logic [3:0]  cfgRxCtrl = 0;
  logic        decValid, decAccept, runtFlag;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmSof(frmSof),
    .frmEof(frmEof), .frmData(frmData), .cfgMa0Lo(cfgMa0Lo),
    .cfgMa0Hi(cfgMa0Hi), .cfgMa1Lo(cfgMa1Lo), .cfgMa1Hi(cfgMa1Hi),
    .cfgGrpLo(cfgGrpLo), .cfgGrpHi(cfgGrpHi), .cfgRxCtrl(cfgRxCtrl),
    .decValid(decValid), .decAccept(decAccept), .runtFlag(runtFlag));

  int    checks = 0, errors = 0;
  string curReq = "R10";
  bit    lastAcc = 0;

  // Behavioural reference state
  bit          mIn = 0;
  int          mCnt = 0;
  logic [7:0]  mAddr [6];
  logic [31:0] sMa0Lo, sMa1Lo, sGrpLo, sGrpHi;
  logic [15:0] sMa0Hi, sMa1Hi;
  logic [3:0]  sCtl;

  function automatic int hashOf(logic [47:0] a);
    int r = 0;
    for (int k = 0; k < 8; k++) r ^= int'((a >> (6 * k)) & 48'h3f);
    return r;
  endfunction

  function automatic bit modelAccept();
    logic [47:0] a;
    logic [63:0] tbl;
    bit acc;
    a   = {mAddr[5], mAddr[4], mAddr[3], mAddr[2], mAddr[1], mAddr[0]};
    tbl = {sGrpHi, sGrpLo};
    acc = (sCtl[0] && a == {sMa0Hi, sMa0Lo}) ||
          (sCtl[1] && a == {sMa1Hi, sMa1Lo}) ||
          (sCtl[3] && a == 48'hffff_ffff_ffff) ||
          ((a[0] || sCtl[2]) && tbl[hashOf(a)]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string msg, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", curReq, msg, got, exp);
    end
  endtask

  // Drive one cycle, predict its result, compare at the next falling edge
  task automatic tick(input bit v, input bit s, input bit e, input logic [7:0] d);
    bit eV = 0, eA = 0, eR = 0;
    frmValid = v; frmSof = s; frmEof = e; frmData = d;
    if (v && (s || mIn)) begin
      if (s) begin
        mIn = 1; mCnt = 0;
        sMa0Lo = cfgMa0Lo; sMa0Hi = cfgMa0Hi; sMa1Lo = cfgMa1Lo;
        sMa1Hi = cfgMa1Hi; sGrpLo = cfgGrpLo; sGrpHi = cfgGrpHi;
        sCtl = cfgRxCtrl;
      end
      if (mCnt < 6) mAddr[mCnt] = d;
      if (mCnt == 5) begin eV = 1; eA = modelAccept(); end
      mCnt++;
      if (e) begin eR = (mCnt < 12); mIn = 0; end
    end
    @(negedge clk);
    check({decValid, decAccept, runtFlag} === {eV, eA, eR},
          "valid/accept/runt", int'({decValid, decAccept, runtFlag}),
          int'({eV, eA, eR}));
    if (decValid) lastAcc = decAccept;
  endtask

  task automatic sendFrame(input logic [47:0] da, input int len, input bit gaps);
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      b = (k < 6) ? da[8*k +: 8] : 8'(k * 7);
      if (gaps && ($urandom % 4 == 0)) tick(0, 0, 0, 8'h00);
      tick(1, k == 0, k == len - 1, b);
    end
    tick(0, 0, 0, 8'h00);
  endtask

  task automatic expectAccept(input logic [47:0] da, input bit exp, input string tag);
    lastAcc = ~exp;
    sendFrame(da, 14, 0);
    curReq = tag;
    check(lastAcc == exp, "accept", int'(lastAcc), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] ucA, ucB, a;
    int idx;
    ucA = 48'h6655_4433_2202;
    ucB = 48'h0b0a_0908_0706;

    // R10: outputs low in and right after reset
    curReq = "R10";
    @(negedge clk);
    repeat (3) tick(0, 0, 0, 8'h00);
    rstN = 1'b1;
    repeat (2) tick(0, 0, 0, 8'h00);

    // R1: unicast 0 from the two words, byte 0 in bits 7:0
    curReq = "R1";
    cfgMa0Lo = ucA[31:0]; cfgMa0Hi = ucA[47:32]; cfgRxCtrl = 4'b0001;
    expectAccept(ucA, 1, "R1");
    cfgRxCtrl = 4'b0000;
    expectAccept(ucA, 0, "R1");

    // R2: unicast 1
    curReq = "R2";
    cfgMa1Lo = ucB[31:0]; cfgMa1Hi = ucB[47:32]; cfgRxCtrl = 4'b0010;
    expectAccept(ucB, 1, "R2");
    expectAccept(ucA, 0, "R2");

    // R3: broadcast
    curReq = "R3";
    cfgRxCtrl = 4'b1000;
    expectAccept(48'hffff_ffff_ffff, 1, "R3");
    cfgRxCtrl = 4'b0000;
    expectAccept(48'hffff_ffff_ffff, 0, "R3");

    // R4/R5: index 1 (low word) and 33 (high word)
    curReq = "R4";
    cfgGrpLo = 32'h0000_0002;
    expectAccept(48'h0000_0000_0001, 1, "R4");
    cfgGrpLo = 32'h0000_0001;
    expectAccept(48'h0000_0000_0001, 0, "R4");
    cfgGrpLo = 0; cfgGrpHi = 32'h0000_0002;
    expectAccept(48'h0000_0000_0021, 1, "R5");
    cfgGrpHi = 32'h0000_0001;
    expectAccept(48'h0000_0000_0021, 0, "R5");
    cfgGrpHi = 0;

    // R6: individual address 00 01 .. hashes to 4, only with control bit 2
    curReq = "R6";
    cfgGrpLo = 32'h0000_0010;
    expectAccept(48'h0000_0000_0100, 0, "R6");
    cfgRxCtrl = 4'b0100;
    expectAccept(48'h0000_0000_0100, 1, "R6");
    cfgRxCtrl = 0; cfgGrpLo = 0;

    // R7: frame ending before its sixth byte gives no strobe
    curReq = "R7";
    cfgRxCtrl = 4'b1000;
    sendFrame(48'hffff_ffff_ffff, 5, 0);
    sendFrame(48'hffff_ffff_ffff, 6, 1);

    // R8: runt boundary at 12 bytes
    curReq = "R8";
    sendFrame(ucA, 11, 0);
    sendFrame(ucA, 12, 0);
    sendFrame(ucA, 1, 0);

    // R9: mid-frame configuration change leaves the frame untouched
    curReq = "R9";
    cfgRxCtrl = 4'b0001;
    lastAcc = 0;
    for (int k = 0; k < 14; k++) begin
      if (k == 2) begin cfgRxCtrl = 0; cfgMa0Lo = 32'h0; end
      tick(1, k == 0, k == 13, (k < 6) ? ucA[8*k +: 8] : 8'h55);
    end
    tick(0, 0, 0, 8'h00);
    check(lastAcc == 1, "accept with frozen settings", int'(lastAcc), 1);
    expectAccept(ucA, 0, "R9");

    // R11: stray bytes ignored, start inside a frame restarts it
    curReq = "R11";
    cfgMa0Lo = ucA[31:0]; cfgRxCtrl = 4'b0001;
    for (int k = 0; k < 8; k++) tick(1, 0, k == 7, 8'hff);
    tick(1, 1, 0, 8'h99); tick(1, 0, 0, 8'h98);
    lastAcc = 0;
    for (int k = 0; k < 12; k++)
      tick(1, k == 0, k == 11, (k < 6) ? ucA[8*k +: 8] : 8'h11);
    tick(0, 0, 0, 8'h00);
    check(lastAcc == 1, "accept after restart", int'(lastAcc), 1);

    // R7: random traffic against the model
    curReq = "R7";
    for (int n = 0; n < 300; n++) begin
      int mode;
      int len;
      mode = $urandom % 5;
      case (mode)
        0: a = {cfgMa0Hi, cfgMa0Lo};
        1: a = {cfgMa1Hi, cfgMa1Lo};
        2: a = 48'hffff_ffff_ffff;
        default: a = {$urandom, $urandom} & 48'hffff_ffff_ffff;
      endcase
      if (n % 3 == 0) begin
        cfgRxCtrl = 4'($urandom);
        cfgGrpLo = $urandom; cfgGrpHi = $urandom;
        if ($urandom % 2 == 0) begin
          cfgMa1Lo = $urandom; cfgMa1Hi = 16'($urandom);
        end
      end
      idx = hashOf(a);
      len = 1 + $urandom % 20;
      for (int k = 0; k < len; k++) begin
        if ($urandom % 8 == 0) tick(0, 0, 0, 8'h00);
        if ($urandom % 16 == 0) cfgRxCtrl = 4'($urandom);
        tick(1, k == 0, k == len - 1, (k < 6) ? a[8*k +: 8] : 8'($urandom));
      end
      if ($urandom % 6 == 0) tick(1, 0, 0, 8'($urandom));
      tick(0, 0, 0, 8'(idx));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule